// File: doc/BRIEF.md
# Thread Block Dispatcher with Occupancy Limits

This block hands out the thread blocks of one kernel to a set of `NUM_SM` multiprocessors. Each multiprocessor has four independent budgets: resident threads, resident blocks, registers and shared memory. A kernel is presented once on a valid/ready launch port with its block count, threads per block, registers per thread and shared memory per block. The register charge of a block is threads per block multiplied by registers per thread. Each block is charged whole against all four budgets, so a multiprocessor can hold as many blocks as the tightest of the four limits allows.

Blocks leave on a valid/ready assign port in ascending ID order, at most one per cycle. Each block carries the index of the multiprocessor that received it, picked round-robin among those with room for one more whole block. When no multiprocessor has room, the next block waits. A retire event names a multiprocessor and gives back one block's full charge there, and the waiting block may then be placed. Back-pressure rules: the assign port holds `assign_valid`, `assign_bid` and `assign_sm` unchanged until `assign_ready` is seen high at a clock edge. The launch port is ready only while no kernel is in flight. A kernel whose single block cannot fit even on an empty multiprocessor is refused with `kernel_err` and never dispatched.

Top module: `blk_dispatcher`

## Requirements
- R1: After reset `launch_ready` is 1 and `assign_valid`, `kernel_done` and `kernel_err` are 0. `launch_ready` is 0 from the cycle after a kernel is accepted until that kernel completes.
- R2: A launch with zero threads, more threads than the thread cap, a register charge (threads times registers per thread) above the register cap, or shared memory above the shared-memory cap raises `kernel_err` in the cycle after acceptance. `launch_ready` stays 1 and no block is ever offered. The next accepted launch clears `kernel_err`.
- R3: Block IDs are offered in ascending order 0, 1, ..., N-1, with at most one handshake per cycle.
- R4: A multiprocessor holds at most min(thread cap / threads, block cap, register cap / register charge, shared cap / shared memory) blocks of a kernel (integer division, a zero shared-memory demand imposing no limit). Defaults: caps of 1536 threads, 8 blocks, 16384 registers and 49152 bytes of shared memory.
- R5: A block is placed only where all four budgets can hold its whole charge. With every multiprocessor full, no block is offered.
- R6: Among the multiprocessors that can take a block, the one after the last granted index (wrapping) is chosen. Each launch restarts the search at multiprocessor 0.
- R7: A retire event on a multiprocessor with resident blocks returns one block's full charge there and counts one block as finished. A retire event on a multiprocessor with no resident block is ignored.
- R8: A block waiting for room is offered once a retire frees a multiprocessor, and it goes to that multiprocessor when it is the only one with room.
- R9: While `assign_valid` is 1 and `assign_ready` is 0, the offer keeps `assign_valid`, `assign_bid` and `assign_sm` unchanged.
- R10: `kernel_done` rises in the cycle after the retire that finishes the last block, together with `launch_ready`. It stays high until the next launch is accepted. A launch with zero blocks and valid demands sets it in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| launch_valid | input | 1 | Kernel launch request |
| launch_ready | output | 1 | No kernel in flight; a launch is accepted |
| launch_blocks | input | BID_W (16) | Number of blocks in the grid |
| launch_threads | input | THR_W (11) | Threads per block |
| launch_regs | input | RPT_W (8) | Registers per thread |
| launch_smem | input | SMEM_W (16) | Shared memory per block |
| retire_valid | input | 1 | One block finished |
| retire_sm | input | SM_W (2) | Multiprocessor the finished block ran on |
| assign_valid | output | 1 | Block placement offered |
| assign_ready | input | 1 | Consumer takes the placement |
| assign_bid | output | BID_W (16) | Block ID |
| assign_sm | output | SM_W (2) | Multiprocessor chosen |
| kernel_done | output | 1 | All blocks placed and retired |
| kernel_err | output | 1 | Last launch refused as unplaceable |

## Verification
The bound checker watches on every cycle that a stalled offer stays frozen, that handshaken IDs step by one, that nothing is offered while the launch port is ready or while the error flag is up, and that the done and error flags rise only after a retire or an accepted launch. Residency per multiprocessor under each of the four limits, the round-robin spread of the first wave, the placement of waiting blocks after a retire, ignored retires on empty multiprocessors, and the completion timing can only be shown by the bench's launch sweeps, whose expected residency is worked out from the caps by integer division.

// File: rtl/blkd_pkg.sv
package blkd_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } blkd_state_e;
endpackage

// File: rtl/blkd_sm_budget.sv
// Occupancy budgets of one multiprocessor. All resident blocks belong to
// the current kernel, so every block carries the same charge.
module blkd_sm_budget #(
  parameter int THR_CAP  = 1536,
  parameter int BLK_CAP  = 8,
  parameter int REG_CAP  = 16384,
  parameter int SMEM_CAP = 49152,
  parameter int THR_W    = 11,
  parameter int REGC_W   = 19,
  parameter int SMEM_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [THR_W-1:0]  chg_thr,
  input  logic [REGC_W-1:0] chg_reg,
  input  logic [SMEM_W-1:0] chg_smem,
  input  logic              take,
  input  logic              give_req,
  output logic              fits,
  output logic              occupied
);
  localparam int UT_W = $clog2(THR_CAP + 1);
  localparam int UB_W = $clog2(BLK_CAP + 1);
  localparam int UR_W = $clog2(REG_CAP + 1);
  localparam int US_W = $clog2(SMEM_CAP + 1);
  localparam int CW   = REGC_W + SMEM_W + THR_W + 2;

  logic [UT_W-1:0] used_thr;
  logic [UB_W-1:0] used_blk;
  logic [UR_W-1:0] used_reg;
  logic [US_W-1:0] used_smem;
  logic            give;
  logic            fit_thr, fit_blk, fit_reg, fit_smem;

  assign occupied = (used_blk != '0);
  assign give     = give_req && occupied;

  // a block is admitted only when every budget holds its whole charge
  assign fit_thr  = (CW'(used_thr)  + CW'(chg_thr))  <= CW'(THR_CAP);
  assign fit_reg  = (CW'(used_reg)  + CW'(chg_reg))  <= CW'(REG_CAP);
  assign fit_smem = (CW'(used_smem) + CW'(chg_smem)) <= CW'(SMEM_CAP);
  assign fit_blk  = used_blk < UB_W'(BLK_CAP);
  assign fits     = fit_thr && fit_reg && fit_smem && fit_blk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      used_thr  <= '0;
      used_blk  <= '0;
      used_reg  <= '0;
      used_smem <= '0;
    end else begin
      used_thr  <= used_thr  + (take ? UT_W'(chg_thr)  : '0)
                             - (give ? UT_W'(chg_thr)  : '0);
      used_blk  <= used_blk  + (take ? UB_W'(1)        : '0)
                             - (give ? UB_W'(1)        : '0);
      used_reg  <= used_reg  + (take ? UR_W'(chg_reg)  : '0)
                             - (give ? UR_W'(chg_reg)  : '0);
      used_smem <= used_smem + (take ? US_W'(chg_smem) : '0)
                             - (give ? US_W'(chg_smem) : '0);
    end
  end
endmodule

// File: rtl/blkd_rr_pick.sv
// Round-robin selection: first requester after the last grant, wrapping.
module blkd_rr_pick #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] last,
  output logic [IW-1:0] gnt,
  output logic          any
);
  logic [IW-1:0] cand;

  always_comb begin
    any  = 1'b0;
    gnt  = '0;
    cand = '0;
    for (int k = 1; k <= N; k++) begin
      cand = IW'((int'(last) + k) % N);
      if (!any && req[cand]) begin
        any = 1'b1;
        gnt = cand;
      end
    end
  end
endmodule

// File: rtl/blk_dispatcher.sv
module blk_dispatcher #(
  parameter int NUM_SM   = 4,
  parameter int THR_CAP  = 1536,
  parameter int BLK_CAP  = 8,
  parameter int REG_CAP  = 16384,
  parameter int SMEM_CAP = 49152,
  parameter int BID_W    = 16,
  parameter int RPT_W    = 8,
  parameter int THR_W    = $clog2(THR_CAP + 1),
  parameter int SMEM_W   = $clog2(SMEM_CAP + 1),
  parameter int SM_W     = (NUM_SM > 1) ? $clog2(NUM_SM) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch_valid,
  output logic              launch_ready,
  input  logic [BID_W-1:0]  launch_blocks,
  input  logic [THR_W-1:0]  launch_threads,
  input  logic [RPT_W-1:0]  launch_regs,
  input  logic [SMEM_W-1:0] launch_smem,
  input  logic              retire_valid,
  input  logic [SM_W-1:0]   retire_sm,
  output logic              assign_valid,
  input  logic              assign_ready,
  output logic [BID_W-1:0]  assign_bid,
  output logic [SM_W-1:0]   assign_sm,
  output logic              kernel_done,
  output logic              kernel_err
);
  import blkd_pkg::*;

  localparam int REGC_W = THR_W + RPT_W;
  localparam logic [THR_W-1:0]  THR_LIM  = THR_W'(THR_CAP);
  localparam logic [REGC_W-1:0] REG_LIM  = REGC_W'(REG_CAP);
  localparam logic [SMEM_W-1:0] SMEM_LIM = SMEM_W'(SMEM_CAP);
  localparam logic [SM_W-1:0]   LAST_INIT = SM_W'(NUM_SM - 1);

  blkd_state_e        state;
  logic [BID_W-1:0]   k_blocks, next_bid, retired;
  logic [THR_W-1:0]   k_thr;
  logic [REGC_W-1:0]  k_reg;
  logic [SMEM_W-1:0]  k_smem;
  logic [SM_W-1:0]    last_sm;
  logic               out_valid;
  logic [BID_W-1:0]   out_bid;
  logic [SM_W-1:0]    out_sm;
  logic               done_q, err_q;

  logic               launch_fire, launch_bad;
  logic [REGC_W-1:0]  reg_chg_in;
  logic               slot_free, want, take;
  logic [NUM_SM-1:0]  fit_v, occ_v, take_v, ret_hit_v;
  logic [SM_W-1:0]    pick_idx;
  logic               pick_any;
  logic               retire_ok, last_retire;

  // ---------------- launch screening ----------------
  assign launch_ready = (state == ST_IDLE);
  assign launch_fire  = launch_valid && launch_ready;
  assign reg_chg_in   = REGC_W'(launch_threads) * REGC_W'(launch_regs);
  assign launch_bad   = (launch_threads == '0)
                     || (launch_threads > THR_LIM)
                     || (reg_chg_in > REG_LIM)
                     || (launch_smem > SMEM_LIM);

  // ---------------- per-multiprocessor budgets ----------------
  generate
    for (genvar i = 0; i < NUM_SM; i++) begin : g_sm
      assign take_v[i]    = take && (pick_idx == SM_W'(i));
      assign ret_hit_v[i] = (state == ST_RUN) && retire_valid
                            && (retire_sm == SM_W'(i));
      blkd_sm_budget #(
        .THR_CAP (THR_CAP),
        .BLK_CAP (BLK_CAP),
        .REG_CAP (REG_CAP),
        .SMEM_CAP(SMEM_CAP),
        .THR_W   (THR_W),
        .REGC_W  (REGC_W),
        .SMEM_W  (SMEM_W)
      ) u_budget (
        .clk     (clk),
        .rst_n   (rst_n),
        .chg_thr (k_thr),
        .chg_reg (k_reg),
        .chg_smem(k_smem),
        .take    (take_v[i]),
        .give_req(ret_hit_v[i]),
        .fits    (fit_v[i]),
        .occupied(occ_v[i])
      );
    end
  endgenerate

  blkd_rr_pick #(
    .N (NUM_SM),
    .IW(SM_W)
  ) u_pick (
    .req (fit_v),
    .last(last_sm),
    .gnt (pick_idx),
    .any (pick_any)
  );

  // ---------------- placement and retire ----------------
  assign slot_free   = !out_valid || assign_ready;
  assign want        = (state == ST_RUN) && (next_bid != k_blocks) && slot_free;
  assign take        = want && pick_any;
  assign retire_ok   = |(ret_hit_v & occ_v);
  assign last_retire = retire_ok && ((retired + 1'b1) == k_blocks);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      k_blocks <= '0;
      k_thr    <= '0;
      k_reg    <= '0;
      k_smem   <= '0;
      next_bid <= '0;
      retired  <= '0;
      last_sm  <= LAST_INIT;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else if (launch_fire) begin
      err_q    <= launch_bad;
      done_q   <= !launch_bad && (launch_blocks == '0);
      k_blocks <= launch_blocks;
      k_thr    <= launch_threads;
      k_reg    <= reg_chg_in;
      k_smem   <= launch_smem;
      next_bid <= '0;
      retired  <= '0;
      last_sm  <= LAST_INIT;
      if (!launch_bad && (launch_blocks != '0)) state <= ST_RUN;
    end else if (state == ST_RUN) begin
      if (take) begin
        next_bid <= next_bid + 1'b1;
        last_sm  <= pick_idx;
      end
      if (retire_ok) begin
        retired <= retired + 1'b1;
      end
      if (last_retire) begin
        state  <= ST_IDLE;
        done_q <= 1'b1;
      end
    end
  end

  // ---------------- offer register ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_bid   <= '0;
      out_sm    <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_bid   <= next_bid;
      out_sm    <= pick_idx;
    end else if (assign_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign assign_valid = out_valid;
  assign assign_bid   = out_bid;
  assign assign_sm    = out_sm;
  assign kernel_done  = done_q;
  assign kernel_err   = err_q;
endmodule

// File: rtl/blkd_chk.sv
module blkd_chk #(
  parameter int BID_W = 16,
  parameter int SM_W  = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             launch_valid,
  input logic             launch_ready,
  input logic             retire_valid,
  input logic             assign_valid,
  input logic             assign_ready,
  input logic [BID_W-1:0] assign_bid,
  input logic [SM_W-1:0]  assign_sm,
  input logic             kernel_done,
  input logic             kernel_err
);
  // R9
  offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (assign_valid && !assign_ready) |=>
      (assign_valid && $stable(assign_bid) && $stable(assign_sm)));

  // R3
  bid_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (assign_valid && assign_ready) |=>
      (!assign_valid || (assign_bid == $past(assign_bid) + 1'b1)));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch_ready |-> !assign_valid);

  // R2
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kernel_err |-> (!assign_valid && launch_ready));

  // R2
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(kernel_err) |-> $past(launch_valid && launch_ready));

  // R10
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(kernel_done) |-> ($past(retire_valid || launch_valid) && launch_ready));
endmodule

bind blk_dispatcher blkd_chk #(
  .BID_W(BID_W),
  .SM_W (SM_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .launch_valid(launch_valid),
  .launch_ready(launch_ready),
  .retire_valid(retire_valid),
  .assign_valid(assign_valid),
  .assign_ready(assign_ready),
  .assign_bid  (assign_bid),
  .assign_sm   (assign_sm),
  .kernel_done (kernel_done),
  .kernel_err  (kernel_err)
);

// File: tb/blk_dispatcher_test.sv
module blk_dispatcher_test;
  localparam int NSM = 4;
  localparam int TCAP = 1536, BCAP = 8, RCAP = 16384, SCAP = 49152;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        launch_valid = 1'b0;
  logic        launch_ready;
  logic [15:0] launch_blocks = '0;
  logic [10:0] launch_threads = '0;
  logic [7:0]  launch_regs = '0;
  logic [15:0] launch_smem = '0;
  logic        retire_valid = 1'b0;
  logic [1:0]  retire_sm = '0;
  logic        assign_valid;
  logic        assign_ready = 1'b0;
  logic [15:0] assign_bid;
  logic [1:0]  assign_sm;
  logic        kernel_done, kernel_err;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;  // 10 ns period

  blk_dispatcher uut (
    .clk(clk), .rst_n(rst_n),
    .launch_valid(launch_valid), .launch_ready(launch_ready),
    .launch_blocks(launch_blocks), .launch_threads(launch_threads),
    .launch_regs(launch_regs), .launch_smem(launch_smem),
    .retire_valid(retire_valid), .retire_sm(retire_sm),
    .assign_valid(assign_valid), .assign_ready(assign_ready),
    .assign_bid(assign_bid), .assign_sm(assign_sm),
    .kernel_done(kernel_done), .kernel_err(kernel_err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic launch(input int nb, input int t, input int r, input int s);
    @(negedge clk);
    launch_valid   = 1'b1;
    launch_blocks  = 16'(nb);
    launch_threads = 11'(t);
    launch_regs    = 8'(r);
    launch_smem    = 16'(s);
    @(negedge clk);
    launch_valid = 1'b0;
  endtask

  task automatic retire(input int sm);
    @(negedge clk);
    retire_valid = 1'b1;
    retire_sm    = 2'(sm);
    @(negedge clk);
    retire_valid = 1'b0;
  endtask

  // wait for an offer, check it, optionally stall, then accept it
  task automatic take_one(input int eb, input int es, input int stall);
    int waited = 0;
    while (!assign_valid && waited < 100) begin
      @(negedge clk);
      waited++;
    end
    chk("R8 offer appears", int'(assign_valid), 1);
    chk("R3 block id", int'(assign_bid), eb);
    chk("R6 chosen sm", int'(assign_sm), es);
    for (int k = 0; k < stall; k++) begin
      @(negedge clk);
      chk("R9 held valid", int'(assign_valid), 1);
      chk("R9 held id", int'(assign_bid), eb);
      chk("R9 held sm", int'(assign_sm), es);
    end
    assign_ready = 1'b1;
    @(negedge clk);
    assign_ready = 1'b0;
  endtask

  function automatic int imin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  task automatic sweep(input int t, input int r, input int s);
    int res, nb, base;
    int order[4] = '{2, 0, 3, 1};
    res = imin(imin(TCAP / t, BCAP), imin(RCAP / (t * r), (s == 0) ? BCAP : SCAP / s));
    nb  = NSM * res + NSM;
    launch(nb, t, r, s);
    chk("R1 busy", int'(launch_ready), 0);
    chk("R2 err clear", int'(kernel_err), 0);
    // first wave spreads round-robin from SM 0
    for (int k = 0; k < NSM * res; k++) take_one(k, k % NSM, (k % 5 == 2) ? 2 : 0);
    repeat (8) @(negedge clk);
    chk("R4 residency cap reached", int'(assign_valid), 0);
    chk("R5 kernel still running", int'(kernel_done), 0);
    // each retire frees exactly one slot, on that SM only
    base = NSM * res;
    for (int j = 0; j < NSM; j++) begin
      retire(order[j]);
      take_one(base + j, order[j], 0);
    end
    for (int sm = 0; sm < NSM; sm++) begin
      for (int q = 0; q < res; q++) begin
        if (sm == NSM - 1 && q == res - 1) chk("R10 done not early", int'(kernel_done), 0);
        retire(sm);
      end
    end
    chk("R10 done", int'(kernel_done), 1);
    chk("R10 ready again", int'(launch_ready), 1);
  endtask

  task automatic bad_launch(input string tag, input int t, input int r, input int s);
    launch(4, t, r, s);
    chk(tag, int'(kernel_err), 1);
    chk("R2 ready stays", int'(launch_ready), 1);
    chk("R2 no done", int'(kernel_done), 0);
    repeat (5) @(negedge clk);
    chk("R2 never offered", int'(assign_valid), 0);
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset ready", int'(launch_ready), 1);
    chk("R1 reset valid", int'(assign_valid), 0);
    chk("R1 reset done", int'(kernel_done), 0);
    chk("R1 reset err", int'(kernel_err), 0);

    bad_launch("R2 too many threads", 1537, 1, 0);
    bad_launch("R2 register charge", 512, 33, 0);
    bad_launch("R2 shared memory", 64, 1, 49153);
    bad_launch("R2 zero threads", 0, 4, 0);

    launch(0, 64, 1, 0);
    chk("R10 empty grid done", int'(kernel_done), 1);
    chk("R2 cleared by launch", int'(kernel_err), 0);
    chk("R10 empty grid ready", int'(launch_ready), 1);

    sweep(512, 1, 0);      // thread-limited: 3
    sweep(128, 1, 0);      // block-slot-limited: 8
    sweep(256, 10, 0);     // register-limited: 6
    sweep(64, 1, 20000);   // shared-memory-limited: 2
    sweep(1024, 16, 0);    // exact register fit: 1
    sweep(96, 20, 12288);  // shared memory: 4

    // retire on an empty SM is ignored
    launch(2, 64, 1, 0);
    take_one(0, 0, 0);
    take_one(1, 1, 0);
    retire(3);
    chk("R7 empty retire ignored", int'(kernel_done), 0);
    retire(0);
    chk("R7 one of two retired", int'(kernel_done), 0);
    retire(1);
    chk("R7 both retired", int'(kernel_done), 1);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule